// File: doc/BRIEF.md
# Parallel USB FIFO Bridge Controller

This block sits inside an FPGA and moves bytes between two on-chip byte streams and an external USB FIFO bridge chip. The two sides share one bidirectional 8-bit bus. Toward the chip, the block watches two active-low status flags, one for "data waiting" and one for "room to send". It drives an active-low read strobe and an active-high write strobe, along with the bus output data and the bus output enable. The FPGA pad ring builds the tri-state buffer from `bus_data_o`, `bus_oe_o` and `bus_data_i`.

Toward the user logic, received bytes leave on a valid/ready stream that holds one byte. Bytes to send arrive on a second valid/ready stream. When both directions have work, the block alternates between them so that neither one starves. When it is idle it drives nothing on the bus, so other devices can use the same wires.

Both flags pass through a multi-flop synchronizer. After each strobe the block waits long enough for a refreshed flag to come through before it samples the flags again.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While `rst_ni` is low, `rd_strobe_no` is 1, `wr_strobe_o` is 0, `bus_oe_o` is 0, `rx_valid_o` is 0 and `tx_ready_o` is 0.
- R2: A write works as follows. `bus_oe_o` rises with the byte on `bus_data_o` one cycle before `wr_strobe_o` rises. `wr_strobe_o` stays high for exactly `WR_HIGH_CYC` cycles. After `wr_strobe_o` falls, the same byte and `bus_oe_o` are held for one more cycle. The byte seen at that falling edge is the byte accepted on `tx_data_i`.
- R3: A transmit byte is accepted (`tx_valid_i` && `tx_ready_o`) only while the synchronized `room_ni` flag is 0. While it is 1, no write strobe occurs.
- R4: A read holds `rd_strobe_no` low for exactly `RD_LOW_CYC` cycles. The block samples `bus_data_i` in the last low cycle and presents that byte on `rx_data_o` with `rx_valid_o`.
- R5: A read starts only while the synchronized `avail_ni` flag is 0 and no received byte is waiting on the output stream.
- R6: While `rx_valid_o` is 1 and `rx_ready_i` is 0, `rx_valid_o` stays 1 and `rx_data_o` stays unchanged.
- R7: `bus_oe_o` is never 1 while `rd_strobe_no` is 0. Between transfers `bus_oe_o` is 0.
- R8: When a transmit byte and a received byte are both pending, reads and writes alternate.
- R9: After each read or write, the strobes stay inactive and `bus_oe_o` stays 0 for at least `SYNC_STAGES`+1 cycles before the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte to send to the chip |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte accepted this cycle |
| rx_data_o | output | 8 | Byte read from the chip |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Consumer takes received byte |
| avail_ni | input | 1 | Chip holds data to read, active low |
| room_ni | input | 1 | Chip can accept a byte, active low |
| rd_strobe_no | output | 1 | Read strobe, active low |
| wr_strobe_o | output | 1 | Write strobe, chip latches on falling edge |
| bus_data_i | input | 8 | Bus value from pad |
| bus_data_o | output | 8 | Bus value to pad |
| bus_oe_o | output | 1 | Pad output enable |

## Verification
A wrong state-machine state shows up at the pads within one cycle. It appears as a strobe pulse that is too long or too short, an output enable that overlaps a read, or a transfer that starts too early after the previous one. The bench measures each of these against the parameters on every pulse. A wrong arbitration bit shows up on the second transfer when both directions are pending, as two operations of the same kind in a row. A lost or corrupted holding register shows up on the receive stream as a wrong byte, or as a valid that drops while it is stalled.

// File: rtl/usb_fifo_bridge_pkg.sv
package usb_fifo_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_HIGH,
    ST_WR_HOLD,
    ST_RD_LOW,
    ST_GAP
  } bridge_state_e;
endpackage

// File: rtl/usb_fifo_bridge_sync.sv
module usb_fifo_bridge_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/usb_fifo_bridge_arb.sv
module usb_fifo_bridge_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic take_i,
  output logic rd_gnt_o,
  output logic wr_gnt_o
);
  logic last_rd_q;

  // on contention, the side not served last wins
  assign rd_gnt_o = rd_req_i & (~wr_req_i | ~last_rd_q);
  assign wr_gnt_o = wr_req_i & (~rd_req_i | last_rd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_rd_q <= 1'b0;
    else if (take_i) last_rd_q <= rd_gnt_o;
  end

  p_alternate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && rd_gnt_o) |=> !(rd_gnt_o && wr_req_i));
  p_alternate_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && wr_gnt_o) |=> !(wr_gnt_o && rd_req_i));
endmodule

// File: rtl/usb_fifo_bridge_fsm.sv
module usb_fifo_bridge_fsm
  import usb_fifo_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WR_HIGH_CYC = 2,
  parameter int RD_LOW_CYC = 2,
  parameter int GAP_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              room_i,
  input  logic              avail_i,
  input  logic              rx_full_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              wr_strobe_o,
  output logic              rd_strobe_no,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_data_o
);
  localparam int MAX_A = (WR_HIGH_CYC > RD_LOW_CYC) ? WR_HIGH_CYC : RD_LOW_CYC;
  localparam int MAX_CYC = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  bridge_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] wr_byte_q;
  logic rd_gnt, wr_gnt, take, rd_req, wr_req;

  assign wr_req = tx_valid_i & room_i;
  assign rd_req = avail_i & ~rx_full_i;
  assign take = (state_q == ST_IDLE) & (rd_gnt | wr_gnt);

  usb_fifo_bridge_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (rd_req),
    .wr_req_i (wr_req),
    .take_i   (take),
    .rd_gnt_o (rd_gnt),
    .wr_gnt_o (wr_gnt)
  );

  always_comb begin
    state_d = state_q;
    cnt_d = cnt_q;
    rd_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_gnt) state_d = ST_WR_SETUP;
        else if (rd_gnt) begin
          state_d = ST_RD_LOW;
          cnt_d = CNT_W'(RD_LOW_CYC - 1);
        end
      end
      ST_WR_SETUP: begin
        state_d = ST_WR_HIGH;
        cnt_d = CNT_W'(WR_HIGH_CYC - 1);
      end
      ST_WR_HIGH: begin
        if (cnt_q == '0) state_d = ST_WR_HOLD;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_WR_HOLD: begin
        state_d = ST_GAP;
        cnt_d = CNT_W'(GAP_CYC - 1);
      end
      ST_RD_LOW: begin
        if (cnt_q == '0) begin
          rd_done_o = 1'b1;
          state_d = ST_GAP;
          cnt_d = CNT_W'(GAP_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_GAP: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q <= '0;
      wr_byte_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q <= cnt_d;
      if (take && wr_gnt) wr_byte_q <= tx_data_i;
    end
  end

  assign tx_ready_o = (state_q == ST_IDLE) & wr_gnt;
  assign rd_byte_o = bus_data_i;
  assign wr_strobe_o = (state_q == ST_WR_HIGH);
  assign rd_strobe_no = (state_q != ST_RD_LOW);
  assign bus_oe_o = (state_q == ST_WR_SETUP) | (state_q == ST_WR_HIGH) |
                    (state_q == ST_WR_HOLD);
  assign bus_data_o = wr_byte_q;

  p_wr_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> bus_oe_o);
  p_wr_fall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_strobe_o) |-> bus_oe_o && $stable(bus_data_o));
  p_wr_room_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> $past(room_i));
  p_rd_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_strobe_no) |-> $past(avail_i) && !$past(rx_full_i));
  p_gap_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_strobe_no) |=> rd_strobe_no && !bus_oe_o && !wr_strobe_o);
  p_gap_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_oe_o) |=> rd_strobe_no && !bus_oe_o);
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge #(
  parameter int DATA_W = 8,
  parameter int WR_HIGH_CYC = 2,
  parameter int RD_LOW_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              avail_ni,
  input  logic              room_ni,
  output logic              rd_strobe_no,
  output logic              wr_strobe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o
);
  // gap lets a flag refreshed after a strobe reach the state machine
  localparam int GAP_CYC = SYNC_STAGES + 1;

  logic [1:0] flags_n;
  logic rd_done;
  logic [DATA_W-1:0] rd_byte;
  logic [DATA_W-1:0] rx_data_q;
  logic rx_valid_q;

  usb_fifo_bridge_sync #(
    .WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({avail_ni, room_ni}),
    .q_o    (flags_n)
  );

  usb_fifo_bridge_fsm #(
    .DATA_W(DATA_W), .WR_HIGH_CYC(WR_HIGH_CYC),
    .RD_LOW_CYC(RD_LOW_CYC), .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .room_i       (~flags_n[0]),
    .avail_i      (~flags_n[1]),
    .rx_full_i    (rx_valid_q),
    .tx_valid_i   (tx_valid_i),
    .tx_data_i    (tx_data_i),
    .tx_ready_o   (tx_ready_o),
    .bus_data_i   (bus_data_i),
    .rd_done_o    (rd_done),
    .rd_byte_o    (rd_byte),
    .wr_strobe_o  (wr_strobe_o),
    .rd_strobe_no (rd_strobe_no),
    .bus_oe_o     (bus_oe_o),
    .bus_data_o   (bus_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_data_q <= '0;
    end else if (rd_done) begin
      rx_valid_q <= 1'b1;
      rx_data_q <= rd_byte;
    end else if (rx_ready_i) begin
      rx_valid_q <= 1'b0;
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_data_o = rx_data_q;

  p_no_contention_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_oe_o && !rd_strobe_no));
  p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o && $stable(rx_data_o));
  p_rd_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_strobe_no) |-> rx_valid_o && rx_data_o == $past(bus_data_i));
endmodule

// File: tb/usb_fifo_bridge_bench.sv
module usb_fifo_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WR_HIGH_CYC = 2;
  localparam int RD_LOW_CYC = 2;
  localparam int SYNC_STAGES = 2;
  localparam int NVEC = 8;
  // bit 8: 1 = chip-to-FPGA read, 0 = FPGA-to-chip write
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h5A}, {1'b0, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'hFF}, {1'b1, 8'h00}, {1'b0, 8'h81}, {1'b1, 8'h7E}
  };

  logic clk = 0;
  logic rst_ni = 0;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0;
  logic tx_ready_o;
  logic [7:0] rx_data_o;
  logic rx_valid_o;
  logic rx_ready = 1;
  logic avail_n, room_n;
  logic rd_strobe_no, wr_strobe_o, bus_oe_o;
  logic [7:0] bus_data_i, bus_data_o;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errs = 0;
  int wd_err = 0;

  // chip model state
  logic [7:0] rd_mem [32];
  int rd_wr_ptr = 0, rd_rd_ptr = 0;
  int room_limit = 1000, wr_count = 0;
  logic [7:0] cap_log [32];
  int cap_n = 0;
  logic [7:0] rx_log [32];
  int rx_n = 0;
  logic op_log [32];
  int op_n = 0;

  assign avail_n = (rd_wr_ptr == rd_rd_ptr);
  assign room_n = (wr_count >= room_limit);
  assign bus_data_i = !rd_strobe_no ? rd_mem[rd_rd_ptr & 31] : 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_fifo_bridge #(
    .DATA_W(8), .WR_HIGH_CYC(WR_HIGH_CYC), .RD_LOW_CYC(RD_LOW_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_usb_fifo_bridge (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready),
    .avail_ni(avail_n), .room_ni(room_n),
    .rd_strobe_no(rd_strobe_no), .wr_strobe_o(wr_strobe_o),
    .bus_data_i(bus_data_i), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o)
  );

  // pad-side monitor and chip model
  logic prev_rd = 1, prev_wr = 0, prev_oe = 0, had_xfer = 0;
  int rd_lo = 0, wr_hi = 0, quiet = 0;
  logic [7:0] wr_byte = 0;

  task automatic mon_chk(input logic ok, input string req, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (bus_oe_o && !rd_strobe_no) mon_chk(0, "R7 oe during read", 1, 0);
      if (prev_rd && !rd_strobe_no) begin
        if (had_xfer) mon_chk(quiet >= SYNC_STAGES + 1, "R9 gap before read", quiet, SYNC_STAGES + 1);
        op_log[op_n & 31] = 1'b1; op_n++;
        rd_lo = 0;
      end
      if (!prev_oe && bus_oe_o) begin
        if (had_xfer) mon_chk(quiet >= SYNC_STAGES + 1, "R9 gap before write", quiet, SYNC_STAGES + 1);
        op_log[op_n & 31] = 1'b0; op_n++;
      end
      if (!rd_strobe_no) rd_lo++;
      if (!prev_rd && rd_strobe_no) begin
        mon_chk(rd_lo == RD_LOW_CYC, "R4 read low width", rd_lo, RD_LOW_CYC);
        rd_rd_ptr++;
        had_xfer = 1;
      end
      if (!prev_wr && wr_strobe_o) begin
        mon_chk(prev_oe, "R2 setup oe", prev_oe, 1);
        wr_hi = 0;
      end
      if (wr_strobe_o) begin wr_hi++; wr_byte = bus_data_o; end
      if (prev_wr && !wr_strobe_o) begin
        mon_chk(wr_hi == WR_HIGH_CYC, "R2 write high width", wr_hi, WR_HIGH_CYC);
        mon_chk(bus_oe_o && bus_data_o == wr_byte, "R2 hold after fall", bus_data_o, wr_byte);
        cap_log[cap_n & 31] = bus_data_o; cap_n++;
        wr_count++;
        had_xfer = 1;
      end
      if (rx_valid_o && rx_ready) begin rx_log[rx_n & 31] = rx_data_o; rx_n++; end
      if (rd_strobe_no && !wr_strobe_o && !bus_oe_o) quiet++; else quiet = 0;
      prev_rd = rd_strobe_no; prev_wr = wr_strobe_o; prev_oe = bus_oe_o;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_rd(input logic [7:0] b);
    rd_mem[rd_wr_ptr & 31] = b;
    rd_wr_ptr++;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1; tx_data = b;
    #1;
    for (int i = 0; i < 500 && !tx_ready_o; i++) begin @(negedge clk); #1; end
    chk(tx_ready_o, "R3 accept", tx_ready_o, 1);
    @(posedge clk); @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_cnt(ref int cnt, input int old);
    for (int i = 0; i < 500 && cnt == old; i++) @(negedge clk);
  endtask

  initial begin
    int old, old2, rd_before;
    logic seen;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(rd_strobe_no == 1 && wr_strobe_o == 0 && bus_oe_o == 0, "R1 strobes", {rd_strobe_no, wr_strobe_o, bus_oe_o}, 3'b100);
    chk(rx_valid_o == 0 && tx_ready_o == 0, "R1 streams", {rx_valid_o, tx_ready_o}, 0);
    rst_ni = 1;

    // table walk: R2 writes and R4 reads
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][8]) begin
        old = rx_n;
        @(negedge clk); push_rd(VEC[v][7:0]);
        wait_cnt(rx_n, old);
        chk(rx_n == old + 1 && rx_log[old & 31] == VEC[v][7:0], "R4 read byte", rx_log[old & 31], VEC[v][7:0]);
      end else begin
        old = cap_n;
        send(VEC[v][7:0]);
        wait_cnt(cap_n, old);
        chk(cap_n == old + 1 && cap_log[old & 31] == VEC[v][7:0], "R2 write byte", cap_log[old & 31], VEC[v][7:0]);
      end
    end
    repeat (10) @(negedge clk);
    chk(bus_oe_o == 0, "R7 idle bus released", bus_oe_o, 0);

    // R3: no room, no write
    room_limit = wr_count;
    repeat (5) @(negedge clk);
    old = cap_n; seen = 0;
    tx_valid = 1; tx_data = 8'h3C;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (tx_ready_o || wr_strobe_o) seen = 1; end
    chk(!seen && cap_n == old, "R3 blocked without room", seen, 0);
    room_limit = wr_count + 1;
    #1;
    for (int i = 0; i < 100 && !tx_ready_o; i++) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); tx_valid = 0;
    wait_cnt(cap_n, old);
    chk(cap_log[old & 31] == 8'h3C, "R3 write after room", cap_log[old & 31], 8'h3C);
    room_limit = 1000;

    // R5/R6: stalled receive stream
    rx_ready = 0;
    rd_before = rd_rd_ptr;
    @(negedge clk); push_rd(8'h11); push_rd(8'h22);
    for (int i = 0; i < 100 && !rx_valid_o; i++) @(negedge clk);
    held = rx_data_o;
    chk(rx_valid_o && held == 8'h11, "R4 first stalled byte", held, 8'h11);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!rx_valid_o || rx_data_o != held) seen = 1; end
    chk(!seen, "R6 held while stalled", seen, 0);
    chk(rd_rd_ptr == rd_before + 1, "R5 no read while full", rd_rd_ptr - rd_before, 1);
    old = rx_n;
    rx_ready = 1;
    for (int i = 0; i < 200 && rx_n < old + 2; i++) @(negedge clk);
    chk(rx_n == old + 2 && rx_log[(old + 1) & 31] == 8'h22, "R5 second byte after drain", rx_log[(old + 1) & 31], 8'h22);

    // R8: both directions pending
    repeat (10) @(negedge clk);
    old = op_n; old2 = cap_n;
    push_rd(8'h31); push_rd(8'h32);
    send(8'h41); send(8'h42);
    for (int i = 0; i < 300 && op_n < old + 4; i++) @(negedge clk);
    chk(op_n == old + 4, "R8 op count", op_n - old, 4);
    for (int k = 1; k < 4; k++)
      chk(op_log[(old + k) & 31] != op_log[(old + k - 1) & 31], "R8 alternate", op_log[(old + k) & 31], !op_log[(old + k - 1) & 31]);
    repeat (20) @(negedge clk);
    chk(cap_log[old2 & 31] == 8'h41 && cap_log[(old2 + 1) & 31] == 8'h42, "R8 write order", cap_log[(old2 + 1) & 31], 8'h42);
    chk(mon_checks > 0, "R9 monitor active", mon_checks, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    wd_err = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errors + mon_errs + wd_err);
    $finish;
  end
endmodule